// File: doc/BRIEF.md
# FSK Bit Synchronizer with Preamble Lock

This block turns a hard-limited, single-bit demodulator output carrying 2-level FSK data into a recovered bit clock and retimed data. It runs on a fast system clock. A sample strobe marks the instants at which the input is looked at. With the default parameters the strobe rate gives 324 samples per nominal bit. Only strobed cycles advance the internal bit-phase counter.

Acquisition starts when receive enable goes high. The phase counter is pulled hard onto the first transitions. Lock is declared once 12 transitions in a row fall inside a ±15 % window around the expected edge phase. While locked, each transition moves the phase by a bounded, smaller step. This lets the loop follow a ±2 % rate error across runs of up to 8 equal bits. Each bit is resolved by a majority vote over its middle quarter. The result is presented on `data_o`. `dclk_o` rises one tenth of a bit before each data update, so the data is stable from 20 % to 60 % of a bit after every rising edge of `dclk_o`. Lock is dropped after 10 bit periods with no transition. Dropping receive enable clears the lock and restarts acquisition.

Top module: `fsk_bit_sync`

## Requirements
- R1: While `rst_ni` is low, `locked_o`, `dclk_o` and `data_o` are all 0.
- R2: `locked_o` rises only after 12 consecutive input transitions, each within ±48 samples (15 % of a bit) of the expected edge phase. It is still 0 after the first 8 preamble bits (7 transitions). It is 1 by the end of a 16-bit alternating preamble that starts with 0.
- R3: `dclk_o` is 0 in the cycle after any cycle in which `locked_o` is 0. While locked, it rises exactly once per received bit.
- R4: `data_o` is the majority of the samples taken in the middle quarter of a bit. When `dclk_o` rises during input bit k, `data_o` equals bit k from 20 % to 60 % of a bit period after that rise. `data_o` changes only while `dclk_o` is high.
- R5: Lock and correct data (R4) hold for bit periods 1.85 % longer and 1.85 % shorter than nominal.
- R6: Once locked, runs of exactly 8 identical bits at those rate extremes neither drop lock nor corrupt data.
- R7: With no input transition, `locked_o` is still 1 after 9.5 bit periods and is 0, with `dclk_o` low, after 10.5 bit periods (the limit is 3240 strobes).
- R8: In the cycle after `rx_en_i` is sampled low, `locked_o` and `dclk_o` are 0. Raising `rx_en_i` again restarts acquisition, and a new preamble locks per R2.
- R9: Cycles without `sample_en_i` do not advance the bit phase. With a strobe every second cycle and bits twice as long in clock cycles, R2 and R4 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample strobe; one sample per strobed cycle |
| rx_en_i | input | 1 | Receive enable; low clears lock and holds the clock low |
| rx_bit_i | input | 1 | Hard-limited demodulated bit stream (asynchronous) |
| dclk_o | output | 1 | Recovered data clock |
| data_o | output | 1 | Retimed data, valid 20–60 % of a bit after each `dclk_o` rise |
| locked_o | output | 1 | Bit synchronizer is locked |

## Verification
The hardest case to reach is worst-case phase drift. This is the bit length at the edge of the rate tolerance, combined with the longest allowed run of identical bits, so that the loop has gone 8 bits without a correction when the next edge arrives. The stimulus sets the bit length to 330 and 318 cycles and sends runs of exactly 8 equal bits after the preamble. A scoreboard then checks the data at both ends of the 20–60 % window after every clock rise. The silence limit is probed on both sides, half a bit before and half a bit after 10 bit periods without a transition.

// File: rtl/fsk_bsync_pkg.sv
package fsk_bsync_pkg;

  function automatic int clamp_int(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/fsk_bsync_sampler.sv
module fsk_bsync_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stb_i,
  input  logic bit_i,
  output logic bit_o,
  output logic edge_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], bit_i};
      if (stb_i) prev_q <= sync_q[SYNC-1];
    end
  end

  assign bit_o  = sync_q[SYNC-1];
  assign edge_o = en_i && stb_i && (sync_q[SYNC-1] != prev_q);

endmodule

// File: rtl/fsk_bsync_phase.sv
module fsk_bsync_phase
  import fsk_bsync_pkg::*;
#(
  parameter int SPB       = 324,
  parameter int LOCK_HITS = 12,
  parameter int WIN_PCT   = 15,
  parameter int SIL_BITS  = 10,
  parameter int TRK_STEP  = SPB / 6,
  parameter int PW        = $clog2(SPB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          stb_i,
  input  logic          edge_i,
  output logic [PW-1:0] phase_o,
  output logic          lock_o
);
  localparam int HALF     = SPB / 2;
  localparam int ACQ_STEP = SPB / 2;
  localparam int WIN      = SPB * WIN_PCT / 100;
  localparam int SIL      = SIL_BITS * SPB;
  localparam int SW       = $clog2(SIL + 1);
  localparam int HW       = $clog2(LOCK_HITS + 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          lock_q;
  logic [HW-1:0] hits_q;
  logic [SW-1:0] sil_q;
  logic          in_win;
  int            err_s, adj_s, nxt_s;

  // signed distance from the ideal edge (phase 0), corrected by a bounded step
  always_comb begin
    err_s = (int'(phase_q) < HALF) ? int'(phase_q) : int'(phase_q) - SPB;
    adj_s = clamp_int(err_s, lock_q ? TRK_STEP : ACQ_STEP);
    nxt_s = int'(phase_q) + 1 - (edge_i ? adj_s : 0);
    if (nxt_s >= SPB) nxt_s = nxt_s - SPB;
    else if (nxt_s < 0) nxt_s = nxt_s + SPB;
    phase_d = PW'(nxt_s);
    in_win  = (err_s <= WIN) && (err_s >= -WIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      lock_q  <= 1'b0;
      hits_q  <= '0;
      sil_q   <= '0;
    end else if (!en_i) begin
      phase_q <= '0;
      lock_q  <= 1'b0;
      hits_q  <= '0;
      sil_q   <= '0;
    end else if (stb_i) begin
      phase_q <= phase_d;
      if (edge_i) begin
        sil_q <= '0;
        if (!lock_q) begin
          if (!in_win) hits_q <= '0;
          else if (hits_q == HW'(LOCK_HITS - 1)) begin
            lock_q <= 1'b1;
            hits_q <= '0;
          end else hits_q <= hits_q + 1'b1;
        end
      end else if (lock_q) begin
        if (sil_q == SW'(SIL - 1)) begin
          lock_q <= 1'b0;
          sil_q  <= '0;
        end else sil_q <= sil_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign lock_o  = lock_q;

  AST_LOCK_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(hits_q) == HW'(LOCK_HITS - 1)); // R2
  AST_SILENCE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) && $past(en_i) |-> $past(sil_q) == SW'(SIL - 1)); // R7
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !lock_q && phase_q == '0); // R8
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !stb_i |=> $stable(phase_q)); // R9

endmodule

// File: rtl/fsk_bsync_slicer.sv
module fsk_bsync_slicer #(
  parameter int SPB     = 324,
  parameter int VOTE_LO = SPB * 3 / 8,
  parameter int VOTE_HI = SPB * 5 / 8,
  parameter int RISE    = VOTE_HI - SPB / 10,
  parameter int FALL    = SPB - SPB / 6 - 1,
  parameter int PW      = $clog2(SPB)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          lock_i,
  input  logic          stb_i,
  input  logic          bit_i,
  input  logic [PW-1:0] phase_i,
  output logic          dclk_o,
  output logic          data_o
);
  localparam int VLEN = VOTE_HI - VOTE_LO;
  localparam int OW   = $clog2(VLEN + 1);

  logic [OW-1:0] ones_q;
  logic          dclk_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      dclk_q <= 1'b0;
      data_q <= 1'b0;
    end else if (!en_i) begin
      ones_q <= '0;
      dclk_q <= 1'b0;
    end else begin
      // high window kept clear of the phase-correction zone around 0
      dclk_q <= lock_i && (phase_i >= PW'(RISE)) && (phase_i < PW'(FALL));
      if (stb_i) begin
        if (phase_i == PW'(VOTE_LO)) ones_q <= OW'(bit_i);
        else if (phase_i > PW'(VOTE_LO) && phase_i < PW'(VOTE_HI))
          ones_q <= ones_q + OW'(bit_i);
        if (phase_i == PW'(VOTE_HI) && lock_i) data_q <= (ones_q > OW'(VLEN / 2));
      end
    end
  end

  assign dclk_o = dclk_q;
  assign data_o = data_q;

  AST_DATA_MOVES_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_q) |-> dclk_q); // R4

endmodule

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync #(
  parameter int SPB         = 324,
  parameter int LOCK_HITS   = 12,
  parameter int WIN_PCT     = 15,
  parameter int SIL_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic rx_en_i,
  input  logic rx_bit_i,
  output logic dclk_o,
  output logic data_o,
  output logic locked_o
);
  localparam int PW        = $clog2(SPB);
  localparam int TRK_STEP  = SPB / 6;
  localparam int VOTE_LO   = SPB * 3 / 8;
  localparam int VOTE_HI   = SPB * 5 / 8;
  localparam int DCLK_RISE = VOTE_HI - SPB / 10;
  localparam int DCLK_FALL = SPB - TRK_STEP - 1;

  logic          bit_s, edge_s, lock_s;
  logic [PW-1:0] phase_s;

  fsk_bsync_sampler #(.SYNC(SYNC_STAGES)) u_sampler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .stb_i (sample_en_i),
    .bit_i (rx_bit_i),
    .bit_o (bit_s),
    .edge_o(edge_s)
  );

  fsk_bsync_phase #(
    .SPB(SPB), .LOCK_HITS(LOCK_HITS), .WIN_PCT(WIN_PCT),
    .SIL_BITS(SIL_BITS), .TRK_STEP(TRK_STEP), .PW(PW)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .stb_i  (sample_en_i),
    .edge_i (edge_s),
    .phase_o(phase_s),
    .lock_o (lock_s)
  );

  fsk_bsync_slicer #(
    .SPB(SPB), .VOTE_LO(VOTE_LO), .VOTE_HI(VOTE_HI),
    .RISE(DCLK_RISE), .FALL(DCLK_FALL), .PW(PW)
  ) u_slicer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .lock_i (lock_s),
    .stb_i  (sample_en_i),
    .bit_i  (bit_s),
    .phase_i(phase_s),
    .dclk_o (dclk_o),
    .data_o (data_o)
  );

  assign locked_o = lock_s;

  AST_DCLK_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |=> !dclk_o); // R3
  AST_RXEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !locked_o && !dclk_o); // R8

endmodule

// File: tb/fsk_bit_sync_tb_top.sv
module fsk_bit_sync_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, rx_en = 1'b0, rx_bit = 1'b0;
  logic dclk, data, locked;
  int   n_chk = 0, n_fail = 0, rises = 0;
  int   div = 1, blen = 324;
  bit   done = 1'b0;
  string cur_req = "R4";
  logic exp_q[$];

  always #4 clk = ~clk;

  fsk_bit_sync dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(stb), .rx_en_i(rx_en),
    .rx_bit_i(rx_bit), .dclk_o(dclk), .data_o(data), .locked_o(locked)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // strobe generator: one strobe every div cycles
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c   = (c + 1 >= div) ? 0 : c + 1;
      stb = (c == 0);
    end
  end

  // driver: pushes each bit as it starts on the line
  task automatic send_bit(input logic v, input int len);
    rx_bit = v;
    exp_q.push_back(v);
    repeat (len) @(negedge clk);
  endtask

  task automatic acquire();
    rx_en = 1'b0;
    repeat (6) @(negedge clk);
    rx_bit = 1'b0;
    rx_en  = 1'b1;
    for (int i = 0; i < 16; i++) begin
      send_bit(logic'(i % 2), blen);
      if (i == 7) begin
        chk("R2 early lock", locked, 1'b0);
        chk("R3 clock idle while unlocked", dclk, 1'b0);
      end
    end
    chk({"R2 lock after preamble ", cur_req}, locked, 1'b1);
  endtask

  // monitor: on each dclk rise, the bit currently on the line is expected
  initial begin
    logic dprev = 1'b0;
    forever begin
      @(negedge clk);
      if (dclk === 1'b1 && !dprev && exp_q.size() > 0) begin
        logic e;
        int   w20, w60;
        rises++;
        while (exp_q.size() > 1) void'(exp_q.pop_front());
        e   = exp_q[0];
        w20 = blen / 5;
        w60 = blen * 3 / 5;
        repeat (w20) @(negedge clk);
        chk({"R4 data at 20% ", cur_req}, data, e);
        repeat (w60 - w20) @(negedge clk);
        chk({"R4 data at 60% ", cur_req}, data, e);
      end
      dprev = dclk;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r0;
    logic lastv;
    repeat (5) @(negedge clk);
    chk("R1 locked in reset", locked, 1'b0);
    chk("R1 dclk in reset", dclk, 1'b0);
    chk("R1 data in reset", data, 1'b0);
    rst_n = 1'b1;

    // nominal rate, mixed data
    cur_req = "R4";
    blen = 324;
    acquire();
    r0 = rises;
    lastv = 1'b0;
    for (int i = 0; i < 24; i++) begin
      lastv = logic'(((i * 5) % 7) < 3);
      send_bit(lastv, blen);
    end
    chk("R3 one rise per bit", logic'(rises - r0 == 24), 1'b1);

    // silence after one final transition
    cur_req = "R7";
    rx_bit = ~lastv;
    exp_q.push_back(~lastv);
    repeat (blen * 19 / 2) @(negedge clk);
    chk("R7 still locked at 9.5 bits", locked, 1'b1);
    repeat (blen) @(negedge clk);
    chk("R7 unlocked at 10.5 bits", locked, 1'b0);
    chk("R7 clock low after loss", dclk, 1'b0);

    // slow bits, runs of 8
    cur_req = "R5 R6 slow";
    blen = 330;
    acquire();
    for (int i = 0; i < 32; i++) send_bit(logic'((i / 8) % 2 == 1), blen);
    chk("R6 lock held slow", locked, 1'b1);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R8 lock cleared", locked, 1'b0);
    chk("R8 clock cleared", dclk, 1'b0);

    // fast bits, runs of 8, after restart
    cur_req = "R5 R6 R8 fast";
    blen = 318;
    acquire();
    for (int i = 0; i < 32; i++) send_bit(logic'((i / 8) % 2 == 1), blen);
    chk("R6 lock held fast", locked, 1'b1);

    // strobe every second cycle
    cur_req = "R9";
    div  = 2;
    blen = 648;
    acquire();
    for (int i = 0; i < 16; i++) send_bit(logic'(((i * 3) % 5) < 2), blen);
    chk("R9 lock held with half-rate strobe", locked, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule